// File: doc/BRIEF.md
# Trace Branch Address Decoder

This block takes a stream of 20-bit trace frames, one per handshake, as they come out of a trace capture memory. For each frame it works out the pipeline status, which may be hidden inside the packet bits when the frame marks a trigger. It keeps a running instruction address, which advances by four on every executed instruction. When a branch is reported, it rebuilds the branch target from a byte-serial packet field. Each frame's packet field holds two bytes. Each byte carries seven address bits and a continuation flag, so an address may arrive spread over several frames.

The input and output are both valid/ready streams. A frame is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input with no extra buffering. The result for each accepted frame appears on the output one cycle later and stays unchanged until it is taken. `skip_cnt` is a plain control input. It is sampled on each branch frame and sets how many sync-marked frames pass before address bytes are collected.

Top module: `trace_branch_decoder`

## Requirements
- R1: A frame holds the status in bits 2:0, the packet field in bits 18:3 and a sync marker in bit 19. For any frame whose status is not 6, `out_status` equals bits 2:0 and `out_trigger` is low.
- R2: On a frame with status 6, `out_trigger` is high and `out_status` is packet bits 2:0 (frame bits 5:3). That real status is used for every other decision on the frame.
- R3: A frame whose resolved status has bits 1:0 not equal to 3 adds 4 to the running address. Wait (3) and trace-off (7) frames leave it unchanged.
- R4: A frame with resolved status 4 or 5 starts collection. Only later frames with bit 19 set take part. The first `skip_cnt` of these (the value sampled on the branch frame) are passed over without taking any bytes.
- R5: The packet bytes of a frame whose raw status is 6 or 7 are never used as address bytes. Such a frame still counts toward the skip.
- R6: The low byte (frame bits 10:3) is used before the high byte (frame bits 18:11). The high byte is used only if the low byte has bit 7 set and fewer than five groups have been taken. An unused high byte is dropped.
- R7: The address is complete at a byte with bit 7 clear, or at the fifth byte. Group k (from 0) then replaces address bits 7k+6..7k, limited to 31. All other bits keep their value. The replacement is applied before that frame's own +4.
- R8: On completion, `out_vbits` becomes the larger of its old value and min(7·groups, 32). It never decreases.
- R9: When completion happens at a fifth byte, `out_reason_vld` is high and `out_reason` is that byte's bits 6:4 (0 normal, 1 trace start, 2 overflow restart, 3 debug exit, 4 periodic sync, 5–7 reserved). Otherwise both are zero.
- R10: A branch frame that arrives while an address is still partial throws the partial bytes away without changing the address, and collection restarts.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R12: After reset `out_valid` is low, the running address and valid-bit count are zero, and no collection is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input frame is valid |
| in_ready | output | 1 | Decoder can accept a frame |
| in_frame | input | 20 | Trace frame |
| skip_cnt | input | SKIP_W | Sync-marked frames skipped after a branch |
| out_valid | output | 1 | Output holds a decoded frame |
| out_ready | input | 1 | Consumer takes the output |
| out_status | output | 3 | Resolved pipeline status |
| out_trigger | output | 1 | Frame was a trigger frame |
| out_addr | output | ADDR_W | Running instruction address after this frame |
| out_vbits | output | VB_W | Number of address bits known |
| out_reason | output | 3 | Branch reason from a fifth address byte |
| out_reason_vld | output | 1 | `out_reason` is meaningful |

## Verification
The assertions assume that `rst_n` is held for at least one clock edge, and that the consumer does not rely on the output changing while it holds `out_ready` low. They make no assumption about frame contents, so any 20-bit pattern, any status mix and any skip value is legal stimulus. The stimulus changes inputs only on the falling edge and keeps `in_valid` and the frame steady until a handshake takes them. It toggles `out_ready` randomly so that stalls land in the middle of address collection. Directed runs cover the ordering corner cases before a long run of random frames.

// File: rtl/trace_dec_pkg.sv
package trace_dec_pkg;
  localparam int FRAME_W = 20;
  localparam int PKT_W   = 16;
  localparam int LANES   = PKT_W / 8;

  typedef enum logic [2:0] {
    ST_EXEC        = 3'd0,
    ST_EXEC_DATA   = 3'd1,
    ST_NOT_EXEC    = 3'd2,
    ST_WAIT        = 3'd3,
    ST_BRANCH      = 3'd4,
    ST_BRANCH_DATA = 3'd5,
    ST_TRIGGER     = 3'd6,
    ST_OFF         = 3'd7
  } status_e;
endpackage

// File: rtl/tbd_frame_classify.sv
module tbd_frame_classify
  import trace_dec_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output status_e            status,
  output logic               trigger,
  output logic               pkt_ok,
  output logic               sync,
  output logic [PKT_W-1:0]   pkt,
  output logic               is_branch,
  output logic               is_exec
);
  status_e raw;

  always_comb begin
    raw       = status_e'(frame[2:0]);
    pkt       = frame[PKT_W+2:3];
    sync      = frame[FRAME_W-1];
    trigger   = (raw == ST_TRIGGER);
    status    = trigger ? status_e'(pkt[2:0]) : raw;
    pkt_ok    = (raw != ST_TRIGGER) && (raw != ST_OFF);
    is_branch = (status == ST_BRANCH) || (status == ST_BRANCH_DATA);
    is_exec   = (status[1:0] != 2'b11);
  end
endmodule

// File: rtl/tbd_group_lane.sv
module tbd_group_lane #(
  parameter int ADDR_W = 32,
  parameter int MAXG   = (ADDR_W + 6) / 7,
  parameter int GRP_W  = $clog2(MAXG + 1)
) (
  input  logic              act_in,
  input  logic [GRP_W-1:0]  grp_in,
  input  logic [ADDR_W-1:0] val_in,
  input  logic [ADDR_W-1:0] mask_in,
  input  logic [7:0]        byte_in,
  output logic              act_out,
  output logic [GRP_W-1:0]  grp_out,
  output logic [ADDR_W-1:0] val_out,
  output logic [ADDR_W-1:0] mask_out,
  output logic              done,
  output logic [2:0]        reason
);
  logic [ADDR_W-1:0] bits_sh, mask_sh;
  logic              last;

  always_comb begin
    bits_sh = ADDR_W'(byte_in[6:0]) << (7 * grp_in);
    mask_sh = ADDR_W'(7'h7f) << (7 * grp_in);
    last    = (grp_in == GRP_W'(MAXG - 1));
    if (act_in) begin
      val_out  = val_in | bits_sh;
      mask_out = mask_in | mask_sh;
      grp_out  = grp_in + GRP_W'(1);
      done     = !byte_in[7] || last;
      act_out  = !done;
      reason   = last ? byte_in[6:4] : 3'd0;
    end else begin
      val_out  = val_in;
      mask_out = mask_in;
      grp_out  = grp_in;
      done     = 1'b0;
      act_out  = 1'b0;
      reason   = 3'd0;
    end
  end
endmodule

// File: rtl/tbd_addr_collect.sv
module tbd_addr_collect
  import trace_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 4,
  parameter int MAXG   = (ADDR_W + 6) / 7,
  parameter int GRP_W  = $clog2(MAXG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_branch,
  input  logic              sync,
  input  logic              pkt_ok,
  input  logic [PKT_W-1:0]  pkt,
  input  logic [SKIP_W-1:0] skip_cnt,
  output logic              commit,
  output logic [ADDR_W-1:0] cval,
  output logic [ADDR_W-1:0] cmask,
  output logic [GRP_W-1:0]  cgrp,
  output logic [2:0]        reason,
  output logic              reason_vld
);
  logic              act_q;
  logic [SKIP_W-1:0] skip_q;
  logic [GRP_W-1:0]  grp_q;
  logic [ADDR_W-1:0] sval_q, smask_q;

  logic              act_c  [LANES+1];
  logic [GRP_W-1:0]  grp_c  [LANES+1];
  logic [ADDR_W-1:0] val_c  [LANES+1];
  logic [ADDR_W-1:0] mask_c [LANES+1];
  logic [LANES-1:0]  done_l;
  logic [2:0]        reason_l [LANES];

  always_comb begin
    act_c[0]  = fire && act_q && sync && (skip_q == '0) && pkt_ok && !is_branch;
    grp_c[0]  = grp_q;
    val_c[0]  = sval_q;
    mask_c[0] = smask_q;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tbd_group_lane #(.ADDR_W(ADDR_W), .MAXG(MAXG), .GRP_W(GRP_W)) u_lane (
      .act_in  (act_c[i]),
      .grp_in  (grp_c[i]),
      .val_in  (val_c[i]),
      .mask_in (mask_c[i]),
      .byte_in (pkt[8*i +: 8]),
      .act_out (act_c[i+1]),
      .grp_out (grp_c[i+1]),
      .val_out (val_c[i+1]),
      .mask_out(mask_c[i+1]),
      .done    (done_l[i]),
      .reason  (reason_l[i])
    );
  end

  always_comb begin
    commit = |done_l;
    cval   = val_c[LANES];
    cmask  = mask_c[LANES];
    cgrp   = grp_c[LANES];
    reason = 3'd0;
    for (int i = 0; i < LANES; i++) reason = reason | reason_l[i];
    reason_vld = commit && (cgrp == GRP_W'(MAXG));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      skip_q  <= '0;
      grp_q   <= '0;
      sval_q  <= '0;
      smask_q <= '0;
    end else if (fire) begin
      if (is_branch) begin
        act_q   <= 1'b1;
        skip_q  <= skip_cnt;
        grp_q   <= '0;
        sval_q  <= '0;
        smask_q <= '0;
      end else if (act_q && sync) begin
        if (skip_q != '0) begin
          skip_q <= skip_q - SKIP_W'(1);
        end else if (pkt_ok) begin
          if (commit) begin
            act_q <= 1'b0;
          end else begin
            grp_q   <= grp_c[LANES];
            sval_q  <= val_c[LANES];
            smask_q <= mask_c[LANES];
          end
        end
      end
    end
  end

  // R6
  grp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (grp_q < GRP_W'(MAXG)));

  // R4
  skip_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q != '0) |-> !commit);

  // R10
  branch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_branch) |=> (act_q && (grp_q == '0) && (smask_q == '0)));
endmodule

// File: rtl/trace_branch_decoder.sv
module trace_branch_decoder
  import trace_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 4,
  parameter int VB_W   = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [19:0]        in_frame,
  input  logic [SKIP_W-1:0]  skip_cnt,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2:0]         out_status,
  output logic               out_trigger,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [VB_W-1:0]    out_vbits,
  output logic [2:0]         out_reason,
  output logic               out_reason_vld
);
  localparam int MAXG  = (ADDR_W + 6) / 7;
  localparam int GRP_W = $clog2(MAXG + 1);

  status_e           st;
  logic              trig, pkt_ok, sync, is_branch, is_exec, fire;
  logic [PKT_W-1:0]  pkt;
  logic              commit, reason_vld;
  logic [ADDR_W-1:0] cval, cmask, addr_nx;
  logic [GRP_W-1:0]  cgrp;
  logic [2:0]        reason;
  logic [VB_W-1:0]   vb_nx;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  tbd_frame_classify u_cls (
    .frame    (in_frame),
    .status   (st),
    .trigger  (trig),
    .pkt_ok   (pkt_ok),
    .sync     (sync),
    .pkt      (pkt),
    .is_branch(is_branch),
    .is_exec  (is_exec)
  );

  tbd_addr_collect #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .MAXG(MAXG), .GRP_W(GRP_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .is_branch (is_branch),
    .sync      (sync),
    .pkt_ok    (pkt_ok),
    .pkt       (pkt),
    .skip_cnt  (skip_cnt),
    .commit    (commit),
    .cval      (cval),
    .cmask     (cmask),
    .cgrp      (cgrp),
    .reason    (reason),
    .reason_vld(reason_vld)
  );

  always_comb begin
    int cap;
    cap = 7 * int'(cgrp);
    if (cap > ADDR_W) cap = ADDR_W;
    vb_nx = out_vbits;
    if (commit && (VB_W'(cap) > out_vbits)) vb_nx = VB_W'(cap);
    addr_nx = commit ? ((out_addr & ~cmask) | (cval & cmask)) : out_addr;
    if (is_exec) addr_nx = addr_nx + ADDR_W'(4);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_status     <= 3'd0;
      out_trigger    <= 1'b0;
      out_addr       <= '0;
      out_vbits      <= '0;
      out_reason     <= 3'd0;
      out_reason_vld <= 1'b0;
    end else if (fire) begin
      out_valid      <= 1'b1;
      out_status     <= st;
      out_trigger    <= trig;
      out_addr       <= addr_nx;
      out_vbits      <= vb_nx;
      out_reason     <= reason_vld ? reason : 3'd0;
      out_reason_vld <= reason_vld;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_status)
                                   && $stable(out_vbits) && $stable(out_reason_vld)));

  // R8
  vbits_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_vbits >= $past(out_vbits)));

  // R8
  vbits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vbits <= VB_W'(ADDR_W));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !commit && !is_exec) |=> $stable(out_addr));

  // R9
  reason_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_reason_vld |-> (out_reason == 3'd0));
endmodule

// File: tb/sim_trace_branch_decoder.sv
module sim_trace_branch_decoder;
  localparam int ADDR_W = 32;
  localparam int SKIP_W = 4;
  localparam int VB_W   = 6;

  typedef struct {
    logic [19:0] f;
    int          skip;
    string       tag;
  } stim_t;

  typedef struct {
    int          st;
    bit          trig;
    logic [31:0] addr;
    int          vb;
    int          rsn;
    bit          rv;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [19:0]       in_frame = '0;
  logic [SKIP_W-1:0] skip_cnt = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [2:0]        out_status;
  logic              out_trigger;
  logic [ADDR_W-1:0] out_addr;
  logic [VB_W-1:0]   out_vbits;
  logic [2:0]        out_reason;
  logic              out_reason_vld;

  always #5 clk = ~clk;

  trace_branch_decoder #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame(in_frame), .skip_cnt(skip_cnt), .out_valid(out_valid),
    .out_ready(out_ready), .out_status(out_status), .out_trigger(out_trigger),
    .out_addr(out_addr), .out_vbits(out_vbits), .out_reason(out_reason),
    .out_reason_vld(out_reason_vld)
  );

  int checks = 0;
  int errors = 0;
  stim_t stim[$];
  exp_t  expq[$];

  // reference state
  logic [31:0] m_addr = '0;
  int          m_vb = 0;
  bit          m_act = 0;
  int          m_skip = 0;
  logic [7:0]  m_pend[$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(bit s, logic [7:0] hi, logic [7:0] lo, logic [2:0] st);
    return {s, hi, lo, st};
  endfunction

  task automatic add(logic [19:0] f, int skip, string tag);
    stim_t s;
    s.f = f; s.skip = skip; s.tag = tag;
    stim.push_back(s);
  endtask

  task automatic model(stim_t s);
    exp_t e;
    int raw, st, grp;
    bit usable, sync, done;
    logic [7:0] b [2];
    raw    = int'(s.f[2:0]);
    e.trig = (raw == 6);
    st     = e.trig ? int'(s.f[5:3]) : raw;
    usable = (raw != 6) && (raw != 7);
    sync   = s.f[19];
    b[0]   = s.f[10:3];
    b[1]   = s.f[18:11];
    done   = 0;
    e.rv   = 0;
    e.rsn  = 0;
    if (st == 4 || st == 5) begin
      m_act  = 1;
      m_skip = s.skip;
      m_pend.delete();
    end else if (m_act && sync) begin
      if (m_skip > 0) m_skip--;
      else if (usable) begin
        for (int i = 0; i < 2 && !done; i++) begin
          m_pend.push_back(b[i]);
          if (!b[i][7] || m_pend.size() == 5) done = 1;
        end
      end
    end
    if (done) begin
      grp = m_pend.size();
      for (int g = 0; g < grp; g++)
        for (int k = 0; k < 7; k++)
          if (7 * g + k < 32) m_addr[7 * g + k] = m_pend[g][k];
      if (((7 * grp > 32) ? 32 : 7 * grp) > m_vb) m_vb = (7 * grp > 32) ? 32 : 7 * grp;
      if (grp == 5) begin
        e.rv  = 1;
        e.rsn = int'(m_pend[4][6:4]);
      end
      m_act = 0;
      m_pend.delete();
    end
    if ((st & 3) != 3) m_addr = m_addr + 32'd4;
    e.st   = st;
    e.addr = m_addr;
    e.vb   = m_vb;
    e.tag  = s.tag;
    expq.push_back(e);
  endtask

  task automatic compare(exp_t e);
    chk(int'(out_status) == e.st, (e.trig ? "R2" : "R1"), "status", out_status, e.st);
    chk(out_trigger == e.trig, "R2", "trigger", out_trigger, e.trig);
    chk(out_addr == e.addr, e.tag, "addr", out_addr, e.addr);
    chk(int'(out_vbits) == e.vb, "R8", "vbits", out_vbits, e.vb);
    chk(out_reason_vld == e.rv, "R9", "reason_vld", out_reason_vld, e.rv);
    chk(int'(out_reason) == e.rsn, "R9", "reason", out_reason, e.rsn);
  endtask

  initial begin
    bit          stall_prev = 0;
    logic [31:0] s_addr = '0;
    logic [2:0]  s_st = '0;
    logic [VB_W-1:0] s_vb = '0;
    int          cyc = 0;

    // R1 R3: plain statuses, no branch
    add(mk(0, 8'h00, 8'h00, 3'd0), 0, "R3");
    add(mk(1, 8'h12, 8'h34, 3'd1), 0, "R3");
    add(mk(0, 8'h00, 8'h00, 3'd2), 0, "R3");
    add(mk(1, 8'hff, 8'hff, 3'd3), 0, "R3");
    add(mk(0, 8'h00, 8'h00, 3'd7), 0, "R3");
    add(mk(0, 8'h00, 8'h00, 3'd0), 0, "R1");
    // R7: two-byte address in one frame
    add(mk(0, 8'h00, 8'h00, 3'd4), 0, "R7");
    add(mk(1, 8'h12, 8'h85, 3'd0), 0, "R7");
    add(mk(0, 8'h00, 8'h00, 3'd3), 0, "R7");
    // R6: low byte completes, high byte dropped
    add(mk(0, 8'h00, 8'h00, 3'd5), 0, "R6");
    add(mk(1, 8'h7f, 8'h2a, 3'd2), 0, "R6");
    // R4: skip two sync frames, ignore non-sync frames
    add(mk(0, 8'h00, 8'h00, 3'd4), 2, "R4");
    add(mk(0, 8'h01, 8'h11, 3'd0), 0, "R4");
    add(mk(1, 8'h02, 8'h22, 3'd0), 0, "R4");
    add(mk(1, 8'h03, 8'h33, 3'd3), 0, "R4");
    add(mk(0, 8'h04, 8'h44, 3'd0), 0, "R4");
    add(mk(1, 8'h05, 8'h55, 3'd0), 0, "R4");
    // R5: trace-off and trigger frames give no bytes
    add(mk(0, 8'h00, 8'h00, 3'd4), 1, "R5");
    add(mk(1, 8'h66, 8'h66, 3'd7), 0, "R5");
    add(mk(1, 8'h01, 8'h02, 3'd6), 0, "R5");
    add(mk(1, 8'h7a, 8'h7b, 3'd7), 0, "R5");
    add(mk(1, 8'h09, 8'h8c, 3'd0), 0, "R5");
    // R9: five bytes with a reason code
    add(mk(0, 8'h00, 8'h00, 3'd4), 0, "R9");
    add(mk(1, 8'h82, 8'h81, 3'd0), 0, "R9");
    add(mk(1, 8'h84, 8'h83, 3'd0), 0, "R9");
    add(mk(1, 8'hff, 8'hb5, 3'd1), 0, "R9");
    // R10: partial address dropped on new branch
    add(mk(0, 8'h00, 8'h00, 3'd4), 0, "R10");
    add(mk(1, 8'h99, 8'hff, 3'd0), 0, "R10");
    add(mk(0, 8'h00, 8'h00, 3'd5), 0, "R10");
    add(mk(0, 8'h00, 8'h00, 3'd2), 0, "R10");
    add(mk(1, 8'h00, 8'h13, 3'd0), 0, "R10");
    // R2: trigger frames hiding real statuses, including a branch
    add(mk(0, 8'h00, 8'h03, 3'd6), 0, "R2");
    add(mk(0, 8'h00, 8'h00, 3'd6), 0, "R2");
    add(mk(1, 8'h00, 8'h04, 3'd6), 0, "R2");
    add(mk(1, 8'h00, 8'h4d, 3'd0), 0, "R2");
    // random frames
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [2:0] st;
      r  = int'($urandom % 16);
      st = (r < 3) ? 3'd4 : (r < 4) ? 3'd5 : (r < 5) ? 3'd6 : (r < 6) ? 3'd7 :
           (r < 8) ? 3'd3 : 3'($urandom % 3);
      add(mk(($urandom % 3) != 0, 8'($urandom), 8'($urandom), st),
          int'($urandom % 3), "R7");
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
    chk(out_addr == '0, "R12", "addr after reset", out_addr, 0);
    chk(out_vbits == '0, "R12", "vbits after reset", out_vbits, 0);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);

    while ((stim.size() != 0 || expq.size() != 0 || out_valid) && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      if (stall_prev) begin
        chk(out_valid && out_addr == s_addr && out_status == s_st && out_vbits == s_vb,
            "R11", "held output", out_addr, s_addr);
      end
      out_ready = (($urandom % 10) < 7);
      if (stim.size() != 0) begin
        in_valid = 1'b1;
        in_frame = stim[0].f;
        skip_cnt = SKIP_W'(stim[0].skip);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      chk(in_ready == (!out_valid || out_ready), "R11", "in_ready", in_ready,
          (!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(0, "R11", "unexpected output", 1, 0);
        else compare(expq.pop_front());
      end
      stall_prev = out_valid && !out_ready;
      s_addr = out_addr;
      s_st   = out_status;
      s_vb   = out_vbits;
      if (in_valid && in_ready) model(stim.pop_front());
    end
    if (cyc >= 100000) chk(0, "R11", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule